// File: doc/BRIEF.md
# HDLC Transmit Framer

This block turns a stream of bytes, each carrying a start-of-packet and an end-of-packet tag, into a serial HDLC bit stream. It reads from a show-ahead transmit FIFO and emits one line bit on each cycle in which the bit enable is high. The bit goes to a downstream line encoder. Between packets the line carries back-to-back flag octets 0x7E.

A packet starts at a byte tagged as its first byte. The framer sends every byte unchanged, including address and control octets, and computes a frame check sequence over them. The sequence type is chosen by a select input when the packet starts. After the byte tagged as last, the framer appends the check sequence and a closing flag. Zero-bit insertion covers everything between the flags.

If the FIFO runs dry inside a packet, the framer ends the packet with an abort run of ones and then sends flags again.

Top module: `hdlc_tx_framer`

## Requirements
- R1: While `rst` is high, `tx_bit` is 1 and `fifo_pop` is 0. The first enabled cycles after reset send a full flag 0x7E, least significant bit first (bit order 0,1,1,1,1,1,1,0).
- R2: At the end of a flag, if the FIFO is empty, another flag follows. An idle line therefore carries continuous flags.
- R3: At the end of a flag, if the FIFO head is tagged start-of-packet, the byte is popped and a frame begins, with that flag as the opening flag. Every frame byte is sent least significant bit first, with its contents not interpreted.
- R4: At the end of a flag, a FIFO head byte without the start-of-packet tag is popped and discarded, and another flag is sent.
- R5: After the byte tagged end-of-packet, the frame check sequence follows, then one closing flag 0x7E. A start-of-packet byte already waiting may use that closing flag as its opening flag.
- R6: `fcs_sel` is sampled when the start-of-packet byte is popped. The encodings are:
  - 0: reflected CRC-CCITT (polynomial 0x1021, preset 0xFFFF, output complemented, 16 bits).
  - 1: reflected CRC-16 (polynomial 0x8005, preset 0, 16 bits).
  - 2 and 3: reflected CRC-32 (polynomial 0x04C11DB7, preset all ones, output complemented, 32 bits).
  - For the ASCII string "123456789" the check values are 0x906E, 0xBB3D and 0xCBF43926.
- R7: The check sequence covers every byte from the start-of-packet byte through the end-of-packet byte. It is sent low octet first, each octet least significant bit first.
- R8: A 0 is inserted after every run of five 1s from the first frame bit through the last check-sequence bit. This includes a run that ends on the last bit before the closing flag or an abort. No 0 is inserted in flags or aborts.
- R9: If the FIFO is empty at a byte boundary inside a frame that has not seen its end-of-packet byte, the framer sends eight 1s, then returns to flags.
- R10: `tx_bit` changes only after an edge at which `bit_en` is high, and advances by exactly one bit per enabled edge.
- R11: `fifo_pop` is high only when `bit_en` and `fifo_valid` are both high, and never in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Advance the line by one bit this cycle |
| fcs_sel | input | 2 | Check-sequence type, sampled at packet start |
| fifo_valid | input | 1 | FIFO head holds a byte |
| fifo_data | input | 8 | FIFO head byte |
| fifo_bop | input | 1 | FIFO head byte starts a packet |
| fifo_eop | input | 1 | FIFO head byte ends a packet |
| fifo_pop | output | 1 | Consume the FIFO head this cycle |
| tx_bit | output | 1 | Serial HDLC line bit |

## Verification
Each line bit is registered: the value driven for an enabled edge appears on `tx_bit` just after that edge. The bench therefore samples one time unit after every rising edge and pairs each enabled edge with the next bit of its expected queue. The next unit (flag, byte, check octet or abort) is chosen, and `fifo_pop` raised combinationally, in the same cycle that carries the last bit of the previous unit. The bench captures `fifo_pop` a quarter period before the edge and makes the reference model's decision at that same edge. The pop, the skip or the abort is thus checked in the cycle it takes effect, and the following bits are compared from the next enabled edge on.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    localparam int BYTE_W        = 8;
    localparam int CRC_W         = 32;
    localparam int FCS_MAX_BYTES = CRC_W / BYTE_W;
    localparam int FCS_IDX_W     = $clog2(FCS_MAX_BYTES + 1);

    localparam logic [BYTE_W-1:0] FLAG_OCTET  = 8'h7E;
    localparam logic [BYTE_W-1:0] ABORT_OCTET = 8'hFF;

    typedef enum logic [1:0] {
        U_FLAG  = 2'd0,
        U_DATA  = 2'd1,
        U_FCS   = 2'd2,
        U_ABORT = 2'd3
    } unit_kind_e;

    typedef enum logic [1:0] {
        FCS_CCITT  = 2'd0,
        FCS_CRC16  = 2'd1,
        FCS_CRC32  = 2'd2,
        FCS_CRC32B = 2'd3
    } fcs_sel_e;

    typedef struct packed {
        unit_kind_e        kind;
        logic [BYTE_W-1:0] data;
    } tx_unit_t;

    typedef struct packed {
        logic [CRC_W-1:0]     poly;
        logic [CRC_W-1:0]     preset;
        logic [CRC_W-1:0]     xorout;
        logic [FCS_IDX_W-1:0] nbytes;
    } crc_cfg_t;

    // Reflected (right-shifting) polynomial forms; 16-bit types live in the low half.
    function automatic crc_cfg_t crc_cfg(fcs_sel_e s);
        crc_cfg_t c;
        case (s)
            FCS_CCITT: c = '{poly: 32'h0000_8408, preset: 32'h0000_FFFF,
                             xorout: 32'h0000_FFFF, nbytes: FCS_IDX_W'(2)};
            FCS_CRC16: c = '{poly: 32'h0000_A001, preset: 32'h0000_0000,
                             xorout: 32'h0000_0000, nbytes: FCS_IDX_W'(2)};
            default:   c = '{poly: 32'hEDB8_8320, preset: 32'hFFFF_FFFF,
                             xorout: 32'hFFFF_FFFF, nbytes: FCS_IDX_W'(4)};
        endcase
        return c;
    endfunction

    function automatic logic [CRC_W-1:0] crc_byte(logic [CRC_W-1:0] crc_in,
                                                  logic [BYTE_W-1:0] d,
                                                  logic [CRC_W-1:0] poly);
        logic [CRC_W-1:0] c;
        logic fb;
        c = crc_in;
        for (int i = 0; i < BYTE_W; i++) begin
            fb = c[0] ^ d[i];
            c  = c >> 1;
            if (fb) c = c ^ poly;
        end
        return c;
    endfunction

    function automatic logic is_stuffable(unit_kind_e k);
        return (k == U_DATA) || (k == U_FCS);
    endfunction

endpackage

// File: rtl/hdlc_bit_serializer.sv
module hdlc_bit_serializer
    import hdlc_tx_pkg::*;
#(
    parameter int ONES_LIMIT = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_en,
    input  tx_unit_t   next_unit,
    output unit_kind_e cur_kind,
    output logic       unit_done,
    output logic       tx_bit
);
    localparam int ONES_W = $clog2(ONES_LIMIT + 1);
    localparam int IDX_W  = $clog2(BYTE_W);
    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(BYTE_W - 1);
    localparam logic [ONES_W-1:0] ONES_STOP = ONES_W'(ONES_LIMIT);

    logic [BYTE_W-1:0] shreg;
    logic [IDX_W-1:0]  bit_idx;
    logic [ONES_W-1:0] ones_run;
    unit_kind_e        kind_q;
    logic              stuff_now;

    assign stuff_now = (ones_run == ONES_STOP);
    assign unit_done = bit_en && !stuff_now && (bit_idx == LAST_IDX);
    assign cur_kind  = kind_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg    <= FLAG_OCTET;
            kind_q   <= U_FLAG;
            bit_idx  <= '0;
            ones_run <= '0;
            tx_bit   <= 1'b1;
        end else if (bit_en) begin
            if (stuff_now) begin
                tx_bit   <= 1'b0;
                ones_run <= '0;
            end else begin
                tx_bit <= shreg[0];
                if (is_stuffable(kind_q) && shreg[0])
                    ones_run <= ones_run + 1'b1;
                else
                    ones_run <= '0;
                if (bit_idx == LAST_IDX) begin
                    shreg   <= next_unit.data;
                    kind_q  <= next_unit.kind;
                    bit_idx <= '0;
                end else begin
                    shreg   <= {1'b0, shreg[BYTE_W-1:1]};
                    bit_idx <= bit_idx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/hdlc_fcs_gen.sv
module hdlc_fcs_gen
    import hdlc_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              byte_take,
    input  logic [BYTE_W-1:0] byte_in,
    input  fcs_sel_e          sel_now,
    input  fcs_sel_e          sel_frame,
    output logic [CRC_W-1:0]  fcs_value
);
    logic [CRC_W-1:0] crc_q;
    crc_cfg_t         cfg_now;
    crc_cfg_t         cfg_frame;

    assign cfg_now   = crc_cfg(sel_now);
    assign cfg_frame = crc_cfg(sel_frame);
    assign fcs_value = crc_q ^ cfg_frame.xorout;

    always_ff @(posedge clk) begin
        if (rst)
            crc_q <= '0;
        else if (frame_start)
            crc_q <= crc_byte(cfg_now.preset, byte_in, cfg_now.poly);
        else if (byte_take)
            crc_q <= crc_byte(crc_q, byte_in, cfg_frame.poly);
    end
endmodule

// File: rtl/hdlc_frame_ctrl.sv
module hdlc_frame_ctrl
    import hdlc_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              unit_done,
    input  unit_kind_e        cur_kind,
    input  logic              fifo_valid,
    input  logic [BYTE_W-1:0] fifo_data,
    input  logic              fifo_bop,
    input  logic              fifo_eop,
    input  fcs_sel_e          sel_now,
    input  logic [CRC_W-1:0]  fcs_value,
    output logic              fifo_pop,
    output logic              frame_start,
    output logic              byte_take,
    output fcs_sel_e          sel_frame,
    output tx_unit_t          next_unit
);
    logic                 eop_seen;
    logic [FCS_IDX_W-1:0] fcs_idx;
    logic [BYTE_W-1:0]    fcs_octet;
    crc_cfg_t             cfg_frame;

    assign cfg_frame = crc_cfg(sel_frame);
    assign fcs_octet = BYTE_W'(fcs_value >> (BYTE_W * int'(fcs_idx)));

    always_comb begin
        next_unit   = '{kind: U_FLAG, data: FLAG_OCTET};
        fifo_pop    = 1'b0;
        frame_start = 1'b0;
        byte_take   = 1'b0;
        if (unit_done) begin
            case (cur_kind)
                U_FLAG: begin
                    if (fifo_valid) begin
                        fifo_pop = 1'b1;
                        if (fifo_bop) begin
                            frame_start = 1'b1;
                            byte_take   = 1'b1;
                            next_unit   = '{kind: U_DATA, data: fifo_data};
                        end
                    end
                end
                U_DATA: begin
                    if (eop_seen) begin
                        next_unit = '{kind: U_FCS, data: fcs_octet};
                    end else if (fifo_valid) begin
                        fifo_pop  = 1'b1;
                        byte_take = 1'b1;
                        next_unit = '{kind: U_DATA, data: fifo_data};
                    end else begin
                        next_unit = '{kind: U_ABORT, data: ABORT_OCTET};
                    end
                end
                U_FCS: begin
                    if (fcs_idx < cfg_frame.nbytes)
                        next_unit = '{kind: U_FCS, data: fcs_octet};
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            eop_seen  <= 1'b0;
            fcs_idx   <= '0;
            sel_frame <= FCS_CCITT;
        end else begin
            if (frame_start) begin
                sel_frame <= sel_now;
                fcs_idx   <= '0;
            end
            if (byte_take)
                eop_seen <= fifo_eop;
            if (unit_done && next_unit.kind == U_FCS)
                fcs_idx <= fcs_idx + 1'b1;
        end
    end
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
    import hdlc_tx_pkg::*;
#(
    parameter int ONES_LIMIT = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_en,
    input  logic [1:0] fcs_sel,
    input  logic       fifo_valid,
    input  logic [7:0] fifo_data,
    input  logic       fifo_bop,
    input  logic       fifo_eop,
    output logic       fifo_pop,
    output logic       tx_bit
);
    unit_kind_e       cur_kind;
    logic             unit_done;
    tx_unit_t         next_unit;
    logic             frame_start;
    logic             byte_take;
    fcs_sel_e         sel_now;
    fcs_sel_e         sel_frame;
    logic [CRC_W-1:0] fcs_value;

    assign sel_now = fcs_sel_e'(fcs_sel);

    hdlc_bit_serializer #(.ONES_LIMIT(ONES_LIMIT)) u_ser (
        .clk       (clk),
        .rst       (rst),
        .bit_en    (bit_en),
        .next_unit (next_unit),
        .cur_kind  (cur_kind),
        .unit_done (unit_done),
        .tx_bit    (tx_bit)
    );

    hdlc_frame_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .unit_done   (unit_done),
        .cur_kind    (cur_kind),
        .fifo_valid  (fifo_valid),
        .fifo_data   (fifo_data),
        .fifo_bop    (fifo_bop),
        .fifo_eop    (fifo_eop),
        .sel_now     (sel_now),
        .fcs_value   (fcs_value),
        .fifo_pop    (fifo_pop),
        .frame_start (frame_start),
        .byte_take   (byte_take),
        .sel_frame   (sel_frame),
        .next_unit   (next_unit)
    );

    hdlc_fcs_gen u_fcs (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .byte_take   (byte_take),
        .byte_in     (fifo_data),
        .sel_now     (sel_now),
        .sel_frame   (sel_frame),
        .fcs_value   (fcs_value)
    );
endmodule

// File: rtl/hdlc_tx_framer_chk.sv
module hdlc_tx_framer_chk
    import hdlc_tx_pkg::*;
#(
    parameter int ONES_LIMIT = 5
) (
    input logic       clk,
    input logic       rst,
    input logic       bit_en,
    input logic       fifo_valid,
    input logic       fifo_pop,
    input logic       tx_bit,
    input unit_kind_e cur_kind
);
    localparam int RUN_W = $clog2(ONES_LIMIT + 4);

    logic             en_q;
    logic             stuffable_q;
    logic [RUN_W-1:0] run_cnt;

    // Tracks 1s emitted inside stuffable units, seen on the line one edge later.
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q        <= 1'b0;
            stuffable_q <= 1'b0;
            run_cnt     <= '0;
        end else begin
            en_q        <= bit_en;
            stuffable_q <= is_stuffable(cur_kind);
            if (en_q) begin
                if (stuffable_q && tx_bit && run_cnt < RUN_W'(ONES_LIMIT + 2))
                    run_cnt <= run_cnt + 1'b1;
                else if (!(stuffable_q && tx_bit))
                    run_cnt <= '0;
            end
        end
    end

    p_pop_gated_r11: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> (bit_en && fifo_valid));

    p_pop_spaced_r11: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |=> !fifo_pop);

    p_line_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(tx_bit));

    p_ones_run_r8: assert property (@(posedge clk) disable iff (rst)
        run_cnt <= RUN_W'(ONES_LIMIT));
endmodule

bind hdlc_tx_framer hdlc_tx_framer_chk #(.ONES_LIMIT(ONES_LIMIT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bit_en     (bit_en),
    .fifo_valid (fifo_valid),
    .fifo_pop   (fifo_pop),
    .tx_bit     (tx_bit),
    .cur_kind   (cur_kind)
);

// File: tb/sim_hdlc_tx_framer.sv
module sim_hdlc_tx_framer;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 150000;

    typedef struct {
        bit   b;
        string tag;
    } exp_bit_t;

    typedef struct {
        bit [7:0] data;
        bit       bop;
        bit       eop;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic [1:0] fcs_sel = 2'd0;
    logic       fifo_valid = 1'b0;
    logic [7:0] fifo_data = 8'h00;
    logic       fifo_bop = 1'b0;
    logic       fifo_eop = 1'b0;
    logic       fifo_pop;
    logic       tx_bit;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    exp_bit_t xq[$];
    item_t    dutq[$];
    item_t    mq[$];
    bit       last_bit = 1'b1;

    hdlc_tx_framer u0 (
        .clk(clk), .rst(rst), .bit_en(bit_en), .fcs_sel(fcs_sel),
        .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_bop(fifo_bop),
        .fifo_eop(fifo_eop), .fifo_pop(fifo_pop), .tx_bit(tx_bit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > MAX_CYCLES && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, MAX_CYCLES);
            finish_run();
        end
    end

    // Reference check value: reflected bitwise form of each CRC type.
    function automatic bit [31:0] ref_fcs(input int sel, input bit [7:0] fb[$], output int nb);
        bit [31:0] poly, c, xo;
        case (sel)
            0: begin poly = 32'h8408; c = 32'hFFFF; xo = 32'hFFFF; nb = 2; end
            1: begin poly = 32'hA001; c = 32'h0;    xo = 32'h0;    nb = 2; end
            default: begin poly = 32'hEDB88320; c = 32'hFFFFFFFF; xo = 32'hFFFFFFFF; nb = 4; end
        endcase
        foreach (fb[k]) begin
            for (int i = 0; i < 8; i++) begin
                bit lsb = c[0] ^ fb[k][i];
                c = c >> 1;
                if (lsb) c = c ^ poly;
            end
        end
        return c ^ xo;
    endfunction

    function automatic void add_octet(input bit [7:0] v, input string tag);
        for (int i = 0; i < 8; i++) xq.push_back('{b: v[i], tag: tag});
    endfunction

    function automatic void model_decide();
        bit [7:0] fb[$];
        exp_bit_t raw[$];
        bit got_eop = 0;
        int ones = 0;
        int nb;
        bit [31:0] f;
        if (mq.size() == 0) begin
            add_octet(8'h7E, "R2");
            return;
        end
        if (!mq[0].bop) begin
            void'(mq.pop_front());
            add_octet(8'h7E, "R4");
            return;
        end
        while (mq.size() > 0 && !got_eop) begin
            item_t it = mq.pop_front();
            fb.push_back(it.data);
            got_eop = it.eop;
        end
        foreach (fb[k])
            for (int i = 0; i < 8; i++) raw.push_back('{b: fb[k][i], tag: "R3"});
        if (got_eop) begin
            f = ref_fcs(int'(fcs_sel), fb, nb);
            for (int i = 0; i < nb * 8; i++) raw.push_back('{b: f[i], tag: "R7"});
        end
        foreach (raw[k]) begin
            xq.push_back(raw[k]);
            ones = raw[k].b ? ones + 1 : 0;
            if (ones == 5) begin
                xq.push_back('{b: 1'b0, tag: "R8"});
                ones = 0;
            end
        end
        if (got_eop) begin
            add_octet(8'h7E, "R5");
        end else begin
            add_octet(8'hFF, "R9");
            add_octet(8'h7E, "R9");
        end
    endfunction

    task automatic step();
        bit pop_s, en_s;
        @(negedge clk);
        bit_en     = ($urandom_range(0, 3) != 0);
        fifo_valid = (dutq.size() > 0);
        fifo_data  = fifo_valid ? dutq[0].data : 8'h00;
        fifo_bop   = fifo_valid ? dutq[0].bop : 1'b0;
        fifo_eop   = fifo_valid ? dutq[0].eop : 1'b0;
        #(CLK_PERIOD/4);
        pop_s = fifo_pop;
        en_s  = bit_en;
        @(posedge clk);
        #1;
        if (pop_s) begin
            chk(dutq.size() > 0, "R11 pop on empty", dutq.size(), 1);
            if (dutq.size() > 0) void'(dutq.pop_front());
        end
        if (en_s) begin
            if (xq.size() == 0) begin
                chk(0, "model underflow", 0, 1);
            end else begin
                exp_bit_t e = xq.pop_front();
                chk(tx_bit === e.b, e.tag, tx_bit, e.b);
                if (xq.size() == 0) model_decide();
            end
        end else begin
            chk(tx_bit === last_bit, "R10 hold", tx_bit, last_bit);
        end
        last_bit = tx_bit;
    endtask

    task automatic push(input bit [7:0] d, input bit b, input bit e);
        dutq.push_back('{data: d, bop: b, eop: e});
        mq.push_back('{data: d, bop: b, eop: e});
    endtask

    task automatic push_str(input string s, input bit term);
        for (int i = 0; i < s.len(); i++)
            push(s[i], i == 0, term && (i == s.len() - 1));
    endtask

    task automatic drain();
        while (dutq.size() > 0 || mq.size() > 0) step();
        repeat (140) step();
        chk(dutq.size() == 0 && mq.size() == 0, "R11 pops match bytes", dutq.size(), 0);
    endtask

    initial begin
        bit [7:0] q9[$];
        int nb;
        // R1: reset state
        repeat (3) begin
            @(posedge clk);
            #1;
            chk(tx_bit === 1'b1 && fifo_pop === 1'b0, "R1 reset", {tx_bit, fifo_pop}, 2'b10);
        end
        add_octet(8'h7E, "R1");
        @(negedge clk);
        rst = 1'b0;

        // R6: reference check values of the three types
        q9 = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        chk(ref_fcs(0, q9, nb) == 32'h906E, "R6 ccitt", ref_fcs(0, q9, nb), 32'h906E);
        chk(ref_fcs(1, q9, nb) == 32'hBB3D, "R6 crc16", ref_fcs(1, q9, nb), 32'hBB3D);
        chk(ref_fcs(2, q9, nb) == 32'hCBF43926, "R6 crc32", ref_fcs(2, q9, nb), 32'hCBF43926);

        repeat (50) step();                  // R2 idle flags

        for (int s = 0; s < 3; s++) begin    // R3 R5 R6 R7 on the check string
            fcs_sel = 2'(s);
            push_str("123456789", 1);
            drain();
        end

        fcs_sel = 2'd1;                      // R8 long runs of ones
        push(8'hFF, 1, 0); push(8'hFF, 0, 0); push(8'h7E, 0, 0); push(8'hF8, 0, 1);
        drain();

        fcs_sel = 2'd0;                      // R4 junk before a frame
        push(8'h55, 0, 0); push(8'hAA, 0, 1);
        push(8'h01, 1, 0); push(8'h02, 0, 1);
        drain();

        fcs_sel = 2'd2;                      // R9 underrun ending on five ones
        push(8'h3C, 1, 0); push(8'hF8, 0, 0);
        drain();

        fcs_sel = 2'd3;                      // R6 encoding 3, single-byte frame
        push(8'h7E, 1, 1);
        drain();

        fcs_sel = 2'd0;                      // R5 back-to-back frames
        push_str("AB", 1);
        push_str("xyz", 1);
        drain();

        finish_run();
    end
endmodule